// File: doc/BRIEF.md
# Paper-Tape Binary Loader Decoder

This block parses a byte stream read from punched paper tape and converts it into memory writes for a machine with 12-bit words and eight 4096-word fields. Bytes arrive on a valid/ready handshake. The block skips blank leader. It recognises one-byte field-select frames and two-byte words. A word is either an origin, which loads the location counter, or a data word. After the trailer it reports whether the checksum matched.

The last word before the trailer is the checksum and must never reach memory. For that reason every data word is held pending until the next frame begins. Only then is it committed to address `field*4096 + location`, and the location advances. A tape that shows none of the features of the checksummed format is treated as a no-checksum tape. On such a tape the final pending word is stored rather than compared. Only one tape segment is handled per reset.

Top module: `tape_loader`

## Requirements
- R1: After reset the block holds `in_ready`=1 and holds `wr_en`, `done`, `sum_err`, `fmt_err` and `no_cksum` at 0.
- R2: Before any frame, bytes of octal 0200 are skipped. An octal 0232 byte seen there stops loading: `done` pulses, no write is issued, and `in_ready` drops.
- R3: A byte with bits 7:6 = 11 is a one-byte field frame. Its bits 5:3 become the field, and the field forms bits 14:12 of each later write address.
- R4: Any other frame byte is the high half of a word. The word value is (high << 6) | low. A low byte above octal 077 raises `fmt_err` and ends the load.
- R5: A word whose high byte has bit 6 set is an origin. Its 12-bit value loads the location counter.
- R6: A data word is written only when the first byte of the next non-trailer frame is accepted. The write appears on the port one cycle after that acceptance. The location then increments modulo 4096.
- R7: The running sum adds both bytes of every origin and of every committed data word, modulo 4096. At the trailer, `sum_err` is set when this sum differs from the pending word. That pending word is not written.
- R8: The tape counts as checksummed once a field frame appears, or once a data word is followed directly by a non-origin word. Otherwise the trailer writes the pending word, sets `no_cksum`, and leaves `sum_err` at 0.
- R9: A data word that arrives before any origin raises `fmt_err` and ends the load.
- R10: A `stream_end` pulse before the load has finished raises `fmt_err` and pulses `done`.
- R11: `done` is a single-cycle pulse, issued one cycle after the terminating byte or event. Afterwards `in_ready` stays 0 until reset.
- R12: Bytes are taken only when `in_valid` and `in_ready` are both high. Idle cycles between bytes do not change any result, and each accepted byte causes at most one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Tape byte present |
| in_data | input | 8 | Tape byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| stream_end | input | 1 | Source has no more bytes |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 15 | Write address: field in 14:12, location in 11:0 |
| wr_data | output | 12 | Write data |
| done | output | 1 | One-cycle end-of-load pulse |
| sum_err | output | 1 | Checksum mismatch (sticky) |
| fmt_err | output | 1 | Malformed tape or early end (sticky) |
| no_cksum | output | 1 | Tape loaded as no-checksum format (sticky) |

## Verification
Every result is registered once. A write, the `done` pulse and the error and format flags therefore show up one clock after the byte or `stream_end` that caused them is taken. The bench drives each byte on a falling edge and holds it through one rising edge. It then samples the outputs at the following falling edge, the first point at which that byte's effect is visible. Writes that arrive with idle gaps between bytes are also logged on falling edges and compared in order against the expected address and data list.

// File: rtl/tl_pkg.sv
// Shared constants and types for the tape loader.
// Assumes 8-bit tape frames and a 12-bit word machine.
package tl_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 12;
    localparam int FLD_W   = 3;
    localparam int ADDR_W  = FLD_W + WORD_W;
    localparam int HALF_W  = WORD_W / 2;
    localparam logic [BYTE_W-1:0] CODE_BLANK = 8'o200;
    localparam logic [BYTE_W-1:0] CODE_STOP  = 8'o232;

    typedef enum logic [1:0] {
        ST_LEAD = 2'd0,  // skipping blank leader
        ST_SEG  = 2'd1,  // expecting the first byte of a frame
        ST_LOW  = 2'd2,  // high byte held, expecting the low byte
        ST_FIN  = 2'd3   // load over, nothing more accepted
    } tl_state_t;
endpackage

// File: rtl/tl_classify.sv
// Pure decode of one tape byte into frame kinds.
// Assumes the byte is stable while it is presented.
module tl_classify
    import tl_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output logic              is_blank,
    output logic              is_stop,
    output logic              is_field,
    output logic [FLD_W-1:0]  fld_val,
    output logic              lo_ok,
    output logic              org_bit
);
    // Classify the byte by its code and top bits.
    always_comb begin
        is_blank = (byte_in == CODE_BLANK);
        is_stop  = (byte_in == CODE_STOP);
        is_field = (byte_in[BYTE_W-1:BYTE_W-2] == 2'b11);
        fld_val  = byte_in[HALF_W-1:HALF_W-FLD_W];
        lo_ok    = (byte_in[BYTE_W-1:HALF_W] == '0);
        org_bit  = byte_in[HALF_W];
    end
endmodule

// File: rtl/tl_cksum.sv
// Running modulo-4096 sum of tape bytes, compared against a word.
// Assumes at most one addition per cycle.
module tl_cksum
    import tl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic [WORD_W-1:0] add_val,
    input  logic [WORD_W-1:0] ref_word,
    output logic              diff_nz
);
    logic [WORD_W-1:0] sum_q;

    // Accumulate the byte sum.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_q <= '0;
        else if (add_en) sum_q <= sum_q + add_val;
    end

    // Nonzero difference between the sum and the reference word.
    always_comb diff_nz = ((sum_q - ref_word) != '0);
endmodule

// File: rtl/tl_locctr.sv
// Field register and 12-bit location counter forming the write address.
// Assumes load and increment never coincide.
module tl_locctr
    import tl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_val,
    input  logic              inc_en,
    input  logic              fld_en,
    input  logic [FLD_W-1:0]  fld_in,
    output logic [ADDR_W-1:0] addr,
    output logic              loc_set
);
    logic [WORD_W-1:0] loc_q;
    logic [FLD_W-1:0]  fld_q;

    // Location: loaded by origins, stepped by commits, wraps at 4096.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_q   <= '0;
            loc_set <= 1'b0;
        end else if (load_en) begin
            loc_q   <= load_val;
            loc_set <= 1'b1;
        end else if (inc_en) begin
            loc_q   <= loc_q + 1'b1;
        end
    end

    // Field register set by field frames.
    always_ff @(posedge clk) begin
        if (!rst_n)      fld_q <= '0;
        else if (fld_en) fld_q <= fld_in;
    end

    always_comb addr = {fld_q, loc_q};
endmodule

// File: rtl/tape_loader.sv
// Tape loader top: frames the byte stream, holds each data word one frame,
// commits it to memory, and checks the checksum at the trailer.
// Assumes one tape segment per reset; stream_end is a single-cycle pulse.
module tape_loader
    import tl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    input  logic              stream_end,
    output logic              wr_en,
    output logic [14:0]       wr_addr,
    output logic [11:0]       wr_data,
    output logic              done,
    output logic              sum_err,
    output logic              fmt_err,
    output logic              no_cksum
);
    tl_state_t         state_q, state_d;
    logic [BYTE_W-1:0] hi_q;
    logic [WORD_W-1:0] pend_q, pend_add_q;
    logic              pend_v_q, bin_q;

    logic is_blank, is_stop, is_field, lo_ok, org_bit;
    logic [FLD_W-1:0]  fld_val;
    logic [ADDR_W-1:0] cur_addr;
    logic              loc_set, diff_nz;

    logic acc, start, commit, trl, last_wr, word_ok, org_fr, dat_fr;
    logic low_bad, noloc_err, end_err, stop_hit, fin_now;
    logic [WORD_W-1:0] word_val, pair_sum, add_val;

    tl_classify u_cls (
        .byte_in(in_data), .is_blank(is_blank), .is_stop(is_stop),
        .is_field(is_field), .fld_val(fld_val), .lo_ok(lo_ok), .org_bit(org_bit)
    );

    // Frame-level decode of the accepted byte against the current state.
    always_comb begin
        acc       = in_valid && in_ready;
        start     = acc && !is_blank &&
                    ((state_q == ST_SEG) || (state_q == ST_LEAD && !is_stop));
        stop_hit  = acc && (state_q == ST_LEAD) && is_stop;
        trl       = acc && (state_q == ST_SEG) && is_blank;
        commit    = start && pend_v_q;
        last_wr   = trl && !bin_q && pend_v_q;
        word_ok   = acc && (state_q == ST_LOW) && lo_ok;
        low_bad   = acc && (state_q == ST_LOW) && !lo_ok;
        org_fr    = word_ok && hi_q[HALF_W];
        dat_fr    = word_ok && !hi_q[HALF_W] && loc_set;
        noloc_err = word_ok && !hi_q[HALF_W] && !loc_set;
        end_err   = stream_end && (state_q != ST_FIN);
        fin_now   = trl || stop_hit || low_bad || noloc_err || end_err;
        word_val  = {hi_q[HALF_W-1:0], in_data[HALF_W-1:0]};
        pair_sum  = {{(WORD_W-BYTE_W){1'b0}}, hi_q} +
                    {{(WORD_W-BYTE_W){1'b0}}, in_data};
        add_val   = commit ? pend_add_q : pair_sum;
    end

    tl_cksum u_sum (
        .clk(clk), .rst_n(rst_n), .add_en(commit || org_fr),
        .add_val(add_val), .ref_word(pend_q), .diff_nz(diff_nz)
    );

    tl_locctr u_loc (
        .clk(clk), .rst_n(rst_n), .load_en(org_fr), .load_val(word_val),
        .inc_en(commit), .fld_en(start && is_field), .fld_in(fld_val),
        .addr(cur_addr), .loc_set(loc_set)
    );

    // Next-state selection for the framing machine.
    always_comb begin
        state_d = state_q;
        if (fin_now)                       state_d = ST_FIN;
        else if (start && !is_field)       state_d = ST_LOW;
        else if (start)                    state_d = ST_SEG;
        else if (word_ok)                  state_d = ST_SEG;
    end

    // Framing state, held high byte, pending word and format mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_LEAD;
            hi_q       <= '0;
            pend_q     <= '0;
            pend_add_q <= '0;
            pend_v_q   <= 1'b0;
            bin_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start && !is_field) hi_q <= in_data;
            if (commit) pend_v_q <= 1'b0;
            if (dat_fr) begin
                pend_q     <= word_val;
                pend_add_q <= pair_sum;
                pend_v_q   <= 1'b1;
            end
            if ((start && is_field) || (commit && !org_bit)) bin_q <= 1'b1;
        end
    end

    // Registered write port, done pulse and sticky status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            done     <= 1'b0;
            sum_err  <= 1'b0;
            fmt_err  <= 1'b0;
            no_cksum <= 1'b0;
        end else begin
            wr_en <= commit || last_wr;
            if (commit || last_wr) begin
                wr_addr <= cur_addr;
                wr_data <= pend_q;
            end
            done <= fin_now;
            if (trl && bin_q && diff_nz)            sum_err  <= 1'b1;
            if (trl && !bin_q)                      no_cksum <= 1'b1;
            if (low_bad || noloc_err || end_err)    fmt_err  <= 1'b1;
        end
    end

    always_comb in_ready = (state_q != ST_FIN);
endmodule

// File: rtl/tape_loader_chk.sv
// Property checker for tape_loader, attached by bind.
// Assumes the same clock and synchronous active-low reset as the design.
module tape_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic wr_en,
    input logic done,
    input logic sum_err,
    input logic fmt_err,
    input logic no_cksum
);
    // R12
    write_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid && in_ready));
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    ready_low_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !in_ready);
    // R7
    sum_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_err |=> sum_err);
    // R9
    fmt_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err);
    // R8
    mode_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sum_err && no_cksum));
endmodule

bind tape_loader tape_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .wr_en(wr_en), .done(done), .sum_err(sum_err), .fmt_err(fmt_err),
    .no_cksum(no_cksum)
);

// File: tb/tape_loader_tb.sv
`timescale 1ns/1ps
module tape_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        stream_end = 1'b0;
    logic        in_ready, wr_en, done, sum_err, fmt_err, no_cksum;
    logic [14:0] wr_addr;
    logic [11:0] wr_data;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    logic [14:0] log_a [16];
    logic [11:0] log_d [16];
    bit finished = 0;

    always #10 clk = ~clk;

    tape_loader u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .stream_end(stream_end), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .sum_err(sum_err),
        .fmt_err(fmt_err), .no_cksum(no_cksum)
    );

    // Main binary tape: byte, expected write, address, data after each byte.
    localparam int NV = 14;
    localparam logic [35:0] VEC [NV] = '{
        {8'o200, 1'b0, 15'o00000, 12'o0000},
        {8'o200, 1'b0, 15'o00000, 12'o0000},
        {8'o102, 1'b0, 15'o00000, 12'o0000},
        {8'o000, 1'b0, 15'o00000, 12'o0000},
        {8'o012, 1'b0, 15'o00000, 12'o0000},
        {8'o034, 1'b0, 15'o00000, 12'o0000},
        {8'o070, 1'b1, 15'o00200, 12'o1234},
        {8'o070, 1'b0, 15'o00000, 12'o0000},
        {8'o310, 1'b1, 15'o00201, 12'o7070},
        {8'o000, 1'b0, 15'o00000, 12'o0000},
        {8'o005, 1'b0, 15'o00000, 12'o0000},
        {8'o003, 1'b1, 15'o10202, 12'o0005},
        {8'o035, 1'b0, 15'o00000, 12'o0000},
        {8'o200, 1'b0, 15'o00000, 12'o0000}
    };

    // Log writes and done pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (wr_cnt < 16) begin
                log_a[wr_cnt] = wr_addr;
                log_d[wr_cnt] = wr_data;
            end
            wr_cnt = wr_cnt + 1;
        end
        if (rst_n && done) done_cnt = done_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; stream_end = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wr_cnt = 0; done_cnt = 0;
    endtask

    // Present one byte for one rising edge, then leave gap idle cycles.
    task automatic send(input logic [7:0] b, input int gap);
        @(negedge clk);
        in_valid = 1'b1; in_data = b;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_list(input logic [7:0] bl [], input int gap);
        foreach (bl[i]) send(bl[i], gap);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check(in_ready && !wr_en && !done && !sum_err && !fmt_err && !no_cksum,
              "R1 reset state", {in_ready, wr_en, done, sum_err, fmt_err, no_cksum}, 6'b100000);

        // Table walk: R3 R4 R5 R6 R7, one-cycle write latency; R12 with varying gaps
        for (int i = 0; i < NV; i++) begin
            logic [7:0] b;
            b = VEC[i][35:28];
            @(negedge clk);
            in_valid = 1'b1; in_data = b;
            @(negedge clk);
            in_valid = 1'b0;
            check(wr_en == VEC[i][27], "R6 write strobe", wr_en, VEC[i][27]);
            if (VEC[i][27]) begin
                check(wr_addr == VEC[i][26:12], "R3 write address", wr_addr, VEC[i][26:12]);
                check(wr_data == VEC[i][11:0], "R5 write data", wr_data, VEC[i][11:0]);
            end
            if (i == NV - 1) check(done == 1'b1, "R11 done after trailer", done, 1);
            repeat (i % 3) @(negedge clk);
        end
        check(!sum_err && !no_cksum && !fmt_err, "R7 good checksum", {sum_err, no_cksum, fmt_err}, 0);
        check(wr_cnt == 3, "R7 checksum word not written", wr_cnt, 3);
        check(!in_ready && done_cnt == 1, "R11 single done, ready low", {in_ready, 4'(done_cnt)}, 1);

        // R7: wrong checksum word
        do_reset();
        send_list('{8'o200, 8'o100, 8'o000, 8'o000, 8'o001, 8'o000, 8'o077, 8'o200}, 0);
        check(sum_err == 1'b1, "R7 checksum mismatch", sum_err, 1);
        check(wr_cnt == 1 && log_a[0] == 15'o0 && log_d[0] == 12'o0001,
              "R7 only data word stored", wr_cnt, 1);

        // R8: no-checksum tape stores final word
        do_reset();
        send_list('{8'o200, 8'o101, 8'o000, 8'o000, 8'o007, 8'o101, 8'o001, 8'o000, 8'o011, 8'o200}, 1);
        check(no_cksum && !sum_err, "R8 no-checksum flag", {no_cksum, sum_err}, 2'b10);
        check(wr_cnt == 2, "R8 write count", wr_cnt, 2);
        check(log_a[0] == 15'o00100 && log_d[0] == 12'o0007, "R8 first write", log_d[0], 12'o0007);
        check(log_a[1] == 15'o00101 && log_d[1] == 12'o0011, "R8 final word stored", log_d[1], 12'o0011);

        // R6: location wraps modulo 4096
        do_reset();
        send_list('{8'o200, 8'o177, 8'o077, 8'o000, 8'o001, 8'o000, 8'o002, 8'o003, 8'o001, 8'o200}, 2);
        check(log_a[0] == 15'o07777 && log_d[0] == 12'o0001, "R6 write at top", log_a[0], 15'o07777);
        check(log_a[1] == 15'o00000 && log_d[1] == 12'o0002, "R6 wrap to zero", log_a[1], 15'o0);
        check(!sum_err && !no_cksum, "R7 wrap tape checksum", {sum_err, no_cksum}, 0);

        // R4: low byte out of range
        do_reset();
        send_list('{8'o200, 8'o100, 8'o100}, 0);
        check(fmt_err && done_cnt == 1, "R4 bad low byte", fmt_err, 1);

        // R9: data before origin
        do_reset();
        send_list('{8'o200, 8'o012, 8'o034}, 0);
        check(fmt_err == 1'b1, "R9 no origin", fmt_err, 1);

        // R10: stream ends inside a word
        do_reset();
        send_list('{8'o200, 8'o100}, 0);
        check(!done && !fmt_err, "R10 no flag before end", {done, fmt_err}, 0);
        @(negedge clk); stream_end = 1'b1;
        @(negedge clk); stream_end = 1'b0;
        check(done && fmt_err, "R10 early end", {done, fmt_err}, 2'b11);

        // R2: stop code in leader; later bytes ignored
        do_reset();
        send(8'o200, 0);
        check(!done && in_ready, "R2 leader skipped", {done, in_ready}, 1);
        @(negedge clk); in_valid = 1'b1; in_data = 8'o232;
        @(negedge clk); in_valid = 1'b0;
        check(done && !in_ready && !fmt_err, "R2 stop code", {done, in_ready, fmt_err}, 3'b100);
        send_list('{8'o100, 8'o000, 8'o000, 8'o001, 8'o002, 8'o003}, 0);
        check(wr_cnt == 0 && done_cnt == 1, "R2 nothing after stop", wr_cnt, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule